// File: doc/BRIEF.md
# Synchronous PCI clock stop gate

This block sits between the 33 MHz and 66 MHz clock phases produced by a clock synthesizer and the clock output drivers. It passes each phase through a per-output gate that opens and closes only while the phase is low, so no output ever shows a shortened high pulse. An active-low stop request can halt the 33 MHz outputs. The request passes through a synchronizer, is sampled once per PCI period, and closes the gates at the next falling edge of the phase. Outputs that run at 66 MHz, outputs with free-running permission and the dedicated always-on output keep toggling while the stop is active.

Two sets of straps are captured right after reset and held until the next reset. One strap decides whether a shared pin carries a clock or the stop input. A two-bit code decides how many members of a four-output selectable group run at 66 MHz. Every output has an enable bit, and some of the ordinary outputs also have a free-running bit. All phases and outputs are treated as data sampled by one fast reference clock `clk_i`.

Top module: `pci_stop_gate`

## Requirements
- R1: While `rst_ni` is low, every clock output is low. After release, no output goes high before its gate has opened during a low phase.
- R2: With the stop role latched (share strap 1) and `stop_ni` low, every ordinary output and every selectable output at 33 MHz stays low, unless that output is exempt.
- R3: A stop closes a 33 MHz output only at a falling edge of its phase. The output then stays low. The gate is closed no more than 20 reference cycles after `stop_ni` falls, given an 8-cycle PCI period.
- R4: After `stop_ni` returns high, a stopped output starts again on a rising edge of its phase with a full first high phase. This happens within 24 reference cycles.
- R5: `fixed_clk_o` is never affected by the stop request.
- R6: The selectable group index i runs from `ph66_i` when i < N_SEL minus the latched code, and from `ph33_i` otherwise. For N_SEL=4: code 00 gives all four at 66 MHz, 01 gives three, 10 gives two, 11 gives one. Outputs running at 66 MHz ignore the stop request.
- R7: An ordinary output with a set `std_free_i` bit ignores the stop request, but only where the matching bit of parameter FREE_MASK is 1 (default bits 3, 4 and 5). A free bit at any other index has no effect.
- R8: An output whose enable bit is 0 is held low. A change of an enable bit at run time takes effect at a falling edge of that output's phase.
- R9: With share strap 0, `share_clk_o` is an ordinary 33 MHz output and `stop_ni` is ignored. With share strap 1, `share_clk_o` is held low and `stop_ni` is honoured.
- R10: Strap inputs are captured on the first clock edge after reset release. Later changes to them have no effect until the next reset.
- R11: Every high pulse on an output lasts exactly one full high phase of its source (4 cycles for 33 MHz and 2 cycles for 66 MHz in an 8-cycle PCI period).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ph33_i | input | 1 | 33 MHz phase, synchronous to clk_i |
| ph66_i | input | 1 | 66 MHz phase, synchronous to clk_i |
| stop_ni | input | 1 | Active-low stop request (input side of the shared pin) |
| share_strap_i | input | 1 | Shared pin role strap: 0 clock, 1 stop input |
| sel_strap_i | input | 2 | Code setting how many selectable outputs run at 66 MHz |
| std_en_i | input | N_STD | Enables of the ordinary outputs |
| std_free_i | input | N_STD | Free-running bits of the ordinary outputs |
| share_en_i | input | 1 | Enable of the shared pin clock |
| fixed_en_i | input | 1 | Enable of the always-on output |
| sel_en_i | input | N_SEL | Enables of the selectable outputs |
| std_clk_o | output | N_STD | Ordinary 33 MHz outputs |
| share_clk_o | output | 1 | Shared pin clock output |
| fixed_clk_o | output | 1 | Always-on 33 MHz output |
| sel_clk_o | output | N_SEL | Selectable 33/66 MHz outputs |

## Verification
A gate register stuck open or closed shows up at the ports within one PCI period, as an output that keeps toggling or stays silent against the expected run mask. A gate updated outside the low phase shows up as a high pulse shorter than its source's high phase, which the pulse-width monitor catches on the next falling edge. A wrong latched strap shows up as a selectable output pulsing at the wrong width, or as the shared pin toggling, within a few cycles of reset. A stop sample that is late or missing leaves stopped outputs toggling past the 20-cycle bound.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic {
    ROLE_CLK  = 1'b0,
    ROLE_STOP = 1'b1
  } share_role_e;

  typedef struct packed {
    share_role_e role;
    logic [1:0]  code;
  } strap_t;

  localparam strap_t STRAP_DEFAULT = '{role: ROLE_STOP, code: 2'b00};

  // selectable output idx runs at 66 MHz when below (n - code)
  function automatic logic sel_fast(input int idx, input logic [1:0] code, input int n);
    return idx < (n - int'(code));
  endfunction

endpackage

// File: rtl/pcs_strap_latch.sv
module pcs_strap_latch
  import pcs_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         share_strap_i,
  input  logic [1:0]   sel_strap_i,
  output strap_t       strap_o
);

  strap_t strap_q;
  logic   cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_q <= STRAP_DEFAULT;
      cap_q   <= 1'b0;
    end else if (!cap_q) begin
      strap_q.role <= share_role_e'(share_strap_i);
      strap_q.code <= sel_strap_i;
      cap_q        <= 1'b1;
    end
  end

  assign strap_o = strap_q;

endmodule

// File: rtl/pcs_stop_sync.sv
module pcs_stop_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ph33_i,
  input  logic stop_ni,
  input  logic honor_i,
  output logic stop_o
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sync_q;
  logic          ph_q;
  logic          stop_q;
  logic          stop_n_eff;

  assign stop_n_eff = honor_i ? stop_ni : 1'b1;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[LAST-1:0], stop_n_eff};
      end
    end else begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= stop_n_eff;
      end
    end
  endgenerate

  // sample once per PCI period, on the phase rising edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      ph_q <= ph33_i;
      if (ph33_i && !ph_q) stop_q <= ~sync_q[LAST];
    end
  end

  assign stop_o = stop_q;

endmodule

// File: rtl/pcs_gate_cell.sv
module pcs_gate_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ph_i,
  input  logic en_i,
  input  logic stop_i,
  input  logic stoppable_i,
  output logic clk_o
);

  logic ph_q;
  logic gate_q;

  // gate moves only on the edge where the phase goes low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      ph_q <= ph_i;
      if (ph_q && !ph_i) gate_q <= en_i & ~(stop_i & stoppable_i);
    end
  end

  assign clk_o = ph_q & gate_q;

endmodule

// File: rtl/pci_stop_gate.sv
module pci_stop_gate
  import pcs_pkg::*;
#(
  parameter int               N_STD       = 7,
  parameter int               N_SEL       = 4,
  parameter int               SYNC_STAGES = 2,
  parameter logic [N_STD-1:0] FREE_MASK   = 7'b0111000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ph33_i,
  input  logic             ph66_i,
  input  logic             stop_ni,
  input  logic             share_strap_i,
  input  logic [1:0]       sel_strap_i,
  input  logic [N_STD-1:0] std_en_i,
  input  logic [N_STD-1:0] std_free_i,
  input  logic             share_en_i,
  input  logic             fixed_en_i,
  input  logic [N_SEL-1:0] sel_en_i,
  output logic [N_STD-1:0] std_clk_o,
  output logic             share_clk_o,
  output logic             fixed_clk_o,
  output logic [N_SEL-1:0] sel_clk_o
);

  strap_t strap;
  logic   stop_req;
  logic   share_is_clk;

  pcs_strap_latch i_strap (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .share_strap_i (share_strap_i),
    .sel_strap_i   (sel_strap_i),
    .strap_o       (strap)
  );

  assign share_is_clk = (strap.role == ROLE_CLK);

  pcs_stop_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ph33_i  (ph33_i),
    .stop_ni (stop_ni),
    .honor_i (!share_is_clk),
    .stop_o  (stop_req)
  );

  generate
    for (genvar k = 0; k < N_STD; k++) begin : g_std
      pcs_gate_cell i_cell (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .ph_i        (ph33_i),
        .en_i        (std_en_i[k]),
        .stop_i      (stop_req),
        .stoppable_i (!(FREE_MASK[k] && std_free_i[k])),
        .clk_o       (std_clk_o[k])
      );
    end

    for (genvar i = 0; i < N_SEL; i++) begin : g_sel
      logic fast;
      assign fast = sel_fast(i, strap.code, N_SEL);
      pcs_gate_cell i_cell (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .ph_i        (fast ? ph66_i : ph33_i),
        .en_i        (sel_en_i[i]),
        .stop_i      (stop_req),
        .stoppable_i (!fast),
        .clk_o       (sel_clk_o[i])
      );
    end
  endgenerate

  pcs_gate_cell i_share (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ph_i        (ph33_i),
    .en_i        (share_en_i && share_is_clk),
    .stop_i      (stop_req),
    .stoppable_i (1'b1),
    .clk_o       (share_clk_o)
  );

  pcs_gate_cell i_fixed (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ph_i        (ph33_i),
    .en_i        (fixed_en_i),
    .stop_i      (stop_req),
    .stoppable_i (1'b0),
    .clk_o       (fixed_clk_o)
  );

endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
  parameter int N_STD = 7,
  parameter int N_SEL = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ph33_i,
  input logic             ph66_i,
  input logic [N_STD-1:0] std_clk_o,
  input logic             share_clk_o,
  input logic             fixed_clk_o,
  input logic [N_SEL-1:0] sel_clk_o
);

  generate
    for (genvar k = 0; k < N_STD; k++) begin : g_std
      p_std_fall_on_phase_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(std_clk_o[k]) |-> !$past(ph33_i));
      p_std_full_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(std_clk_o[k]) |-> ($past(ph33_i) && !$past(ph33_i, 2)));
    end
  endgenerate

  p_sel0_fast_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_clk_o[0]) |-> ($past(ph66_i) && !$past(ph66_i, 2)));

  p_fixed_fall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fixed_clk_o) |-> !$past(ph33_i));

  p_share_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(share_clk_o) |-> ($past(ph33_i) && !$past(ph33_i, 2)));

endmodule

bind pci_stop_gate pcs_checker #(.N_STD(N_STD), .N_SEL(N_SEL)) i_pcs_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ph33_i      (ph33_i),
  .ph66_i      (ph66_i),
  .std_clk_o   (std_clk_o),
  .share_clk_o (share_clk_o),
  .fixed_clk_o (fixed_clk_o),
  .sel_clk_o   (sel_clk_o)
);

// File: tb/test_pci_stop_gate.sv
module test_pci_stop_gate;

  localparam int CLK_PERIOD = 10;
  localparam int N_STD = 7;
  localparam int N_SEL = 4;
  localparam int N_OUT = N_STD + 2 + N_SEL;

  typedef struct packed {
    logic        sh;
    logic [1:0]  code;
    logic        stop_n;
    logic [6:0]  std_en;
    logic [6:0]  frun;
    logic        sh_en;
    logic        fx_en;
    logic [3:0]  sel_en;
    logic [12:0] exp;   // {sel[3:0], fixed, share, std[6:0]}
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{1'b1, 2'b00, 1'b1, 7'h7F, 7'h00,     1'b1, 1'b1, 4'hF, 13'b1111_1_0_1111111},
    '{1'b1, 2'b00, 1'b0, 7'h7F, 7'h00,     1'b1, 1'b1, 4'hF, 13'b1111_1_0_0000000},
    '{1'b1, 2'b11, 1'b0, 7'h7F, 7'b0111000, 1'b1, 1'b1, 4'hF, 13'b0001_1_0_0111000},
    '{1'b1, 2'b01, 1'b0, 7'h7F, 7'b1000111, 1'b1, 1'b1, 4'hF, 13'b0111_1_0_0000000},
    '{1'b0, 2'b10, 1'b0, 7'h7F, 7'h00,     1'b1, 1'b1, 4'hF, 13'b1111_1_1_1111111},
    '{1'b1, 2'b10, 1'b1, 7'b1010101, 7'h00, 1'b1, 1'b0, 4'b1010, 13'b1010_0_0_1010101},
    '{1'b1, 2'b10, 1'b0, 7'h7F, 7'h00,     1'b1, 1'b1, 4'hF, 13'b0011_1_0_0000000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ph33 = 1'b0, ph66 = 1'b0;
  logic stop_n = 1'b1;
  logic share_strap = 1'b1;
  logic [1:0] sel_strap = 2'b00;
  logic [N_STD-1:0] std_en = '1, std_free = '0;
  logic share_en = 1'b1, fixed_en = 1'b1;
  logic [N_SEL-1:0] sel_en = '1;
  logic [N_STD-1:0] std_clk;
  logic share_clk, fixed_clk;
  logic [N_SEL-1:0] sel_clk;
  logic [N_OUT-1:0] obs;

  int total = 0, bad = 0, runt = 0, cyc = 0;
  int hi_cnt [N_OUT];
  logic [N_OUT-1:0] seen = '0;
  logic [1:0] lat_code = 2'b00;
  logic [2:0] pcnt = 3'd0;
  string vtag [7];

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_stop_gate #(.N_STD(N_STD), .N_SEL(N_SEL)) i_pci_stop_gate (
    .clk_i(clk), .rst_ni(rst_n), .ph33_i(ph33), .ph66_i(ph66), .stop_ni(stop_n),
    .share_strap_i(share_strap), .sel_strap_i(sel_strap),
    .std_en_i(std_en), .std_free_i(std_free), .share_en_i(share_en),
    .fixed_en_i(fixed_en), .sel_en_i(sel_en),
    .std_clk_o(std_clk), .share_clk_o(share_clk), .fixed_clk_o(fixed_clk),
    .sel_clk_o(sel_clk)
  );

  assign obs = {sel_clk, fixed_clk, share_clk, std_clk};

  function automatic int exp_w(int k);
    if (k >= N_STD + 2) return ((k - N_STD - 2) < (N_SEL - int'(lat_code))) ? 2 : 4;
    return 4;
  endfunction

  // pulse-width monitor and phase generator (8-cycle PCI period)
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int k = 0; k < N_OUT; k++) hi_cnt[k] = 0;
    end else begin
      for (int k = 0; k < N_OUT; k++) begin
        if (obs[k]) begin
          hi_cnt[k]++;
          seen[k] = 1'b1;
        end else begin
          if (hi_cnt[k] != 0 && hi_cnt[k] != exp_w(k)) runt++;
          hi_cnt[k] = 0;
        end
      end
    end
    pcnt = pcnt + 3'd1;
    ph33 = ~pcnt[2];
    ph66 = ~pcnt[1];
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic sh, input logic [1:0] code);
    step(1);
    rst_n = 1'b0;
    share_strap = sh;
    sel_strap = code;
    lat_code = code;
    step(3);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic measure(input int settle, input int win);
    step(settle);
    seen = '0;
    runt = 0;
    step(win);
  endtask

  initial begin
    vtag[0] = "R6"; vtag[1] = "R2"; vtag[2] = "R7"; vtag[3] = "R7";
    vtag[4] = "R9"; vtag[5] = "R8"; vtag[6] = "R6";

    // R1: outputs low while reset is held with phases running
    step(6);
    chk(obs == '0, "R1 reset low", 32'(obs), 0);

    for (int v = 0; v < 7; v++) begin
      stop_n   = VEC[v].stop_n;
      std_en   = VEC[v].std_en;
      std_free = VEC[v].frun;
      share_en = VEC[v].sh_en;
      fixed_en = VEC[v].fx_en;
      sel_en   = VEC[v].sel_en;
      do_reset(VEC[v].sh, VEC[v].code);
      measure(40, 48);
      chk(seen == VEC[v].exp, {vtag[v], " run mask"}, 32'(seen), 32'(VEC[v].exp));
      chk(runt == 0, "R11 pulse width", runt, 0);
    end

    // R3/R4/R5: stop and restart timing
    stop_n = 1'b1; std_en = '1; std_free = '0; share_en = 1'b1; fixed_en = 1'b1; sel_en = '1;
    do_reset(1'b1, 2'b00);
    step(40);
    stop_n = 1'b0;
    measure(20, 40);
    chk(seen[6:0] == 7'h00, "R3 stopped", 32'(seen[6:0]), 0);
    chk(seen[7] == 1'b0, "R9 share low", 32'(seen[7]), 0);
    chk(seen[8] == 1'b1, "R5 fixed runs", 32'(seen[8]), 1);
    chk(seen[12:9] == 4'hF, "R6 fast ignore stop", 32'(seen[12:9]), 32'hF);
    chk(runt == 0, "R3 clean stop", runt, 0);
    stop_n = 1'b1;
    seen = '0;
    step(24);
    chk(seen[6:0] == 7'h7F, "R4 resume", 32'(seen[6:0]), 32'h7F);
    step(16);
    chk(runt == 0, "R4 full first pulse", runt, 0);

    // R10: straps changed after capture are ignored
    stop_n = 1'b1;
    do_reset(1'b1, 2'b00);
    share_strap = 1'b0;
    sel_strap = 2'b11;
    stop_n = 1'b0;
    measure(40, 40);
    chk(seen == 13'b1111_1_0_0000000, "R10 strap hold", 32'(seen), 32'(13'b1111_1_0_0000000));
    chk(runt == 0, "R10 widths keep latched code", runt, 0);

    // R8: run-time enable change
    stop_n = 1'b1;
    do_reset(1'b1, 2'b00);
    step(40);
    std_en[2] = 1'b0;
    sel_en[1] = 1'b0;
    measure(20, 40);
    chk(seen[2] == 1'b0 && seen[10] == 1'b0, "R8 disabled low",
        32'({seen[10], seen[2]}), 0);
    chk(seen[1] == 1'b1 && seen[11] == 1'b1, "R8 others run",
        32'({seen[11], seen[1]}), 3);
    chk(runt == 0, "R8 clean disable", runt, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule